// File: doc/BRIEF.md
# LED and Switch Register Peripheral

This block is a bus-slave peripheral that sits behind a simple processor-side register port. Address decode happens upstream: by the time a transfer reaches the block it has been reduced to one-hot read and write chip-enable vectors, one bit per register, with register n at base + 4n. The block holds a single 32-bit register at offset 0. Software writes it a byte lane at a time under byte-enable control. The least significant byte of that register drives eight LED outputs at all times.

Reads never return the register. The read data bus always carries the eight switch inputs, zero-extended, after they pass through a two-stage synchronizer. A program therefore polls the switches with a read and shows a pattern on the LEDs with a write.

Acknowledges are combinational. Each one is the OR of its chip-enable vector. The error flag never rises.

All bus bit numbering is MSB-first: bit 0 is the most significant bit and bit 31 the least significant. Byte lane k covers bits 8k to 8k+7 and is enabled by byte-enable bit k. Lane 3 (bits 24 to 31) is therefore the least significant byte.

Top module: `ledsw_regblk`

## Requirements
- R1: A synchronous active-high reset, sampled on the rising clock edge, clears the register to zero, so the LED output is 0x00 one clock after reset. The same reset also clears the switch synchronizer, so read data is zero.
- R2: On a clock edge where write chip-enable bit 0 is set, each byte lane k (bits 8k to 8k+7, MSB-first) takes the write data of that lane only if byte-enable bit k is set; lanes with a clear enable keep their value.
- R3: LED output bits 0 to 7 equal register bits 24 to 31 (lane 3) continuously. A write that sets byte-enable bit 3 shows its data bits 24 to 31 on the LEDs after the clock edge that accepts it.
- R4: Read data bits 0 to 23 are always zero and bits 24 to 31 carry the synchronized switch value, whatever the register holds.
- R5: Read data is driven with the switch value at all times, including cycles with no read chip enable set.
- R6: The write acknowledge is high in exactly the cycles where any write chip-enable bit is set, and the read acknowledge in exactly the cycles where any read chip-enable bit is set, with no clock delay.
- R7: The error output is always 0.
- R8: A switch change reaches the read data bus after exactly two rising clock edges; after only one edge the old value is still shown.
- R9: A write with all four byte enables clear is acknowledged but leaves the register, and so the LEDs, unchanged.
- R10: Write data and byte enables presented while write chip-enable bit 0 is clear do not change the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 32 | Write data, bit 0 most significant |
| byte_en | input | 4 | Byte-lane enables, bit k covers data bits 8k to 8k+7 |
| rd_ce | input | CE_W | One-hot read chip enables, bit n selects base + 4n |
| wr_ce | input | CE_W | One-hot write chip enables, bit n selects base + 4n |
| rd_data | output | 32 | Zero-extended synchronized switch value |
| rd_ack | output | 1 | Read acknowledge, OR of rd_ce |
| wr_ack | output | 1 | Write acknowledge, OR of wr_ce |
| err | output | 1 | Bus error, tied low |
| sw_in | input | 8 | Asynchronous switch inputs |
| led_out | output | 8 | LED drive, register bits 24 to 31 |

## Verification
Most faults show at the ports within one clock. A lane update applied under the wrong byte enable, or lost, changes the LED byte at the next edge. A wrong acknowledge shows in the same cycle as the chip enable. A synchronizer with too few or too many stages shows the new switch value one edge early or one edge late on the read bus.

Lanes 0 to 2 of the register cannot be read back, by definition. They are exercised only for their side effect: writes that touch only those lanes must leave the LED byte unchanged.

// File: rtl/ledsw_pkg.sv
`timescale 1ns/1ps
package ledsw_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = BUS_W / LANE_W;
    localparam int unsigned PIN_W  = 8;
    localparam int unsigned PIN_LO = BUS_W - PIN_W;

    typedef logic [0:BUS_W-1] word_t;
    typedef logic [0:PIN_W-1] pins_t;
    typedef logic [0:LANES-1] lanes_t;

    // write request as seen by the storage
    typedef struct packed {
        logic   hit;
        lanes_t lane_en;
        word_t  data;
    } wr_req_t;

    // place a pin vector in the low-order bits (highest indices) of a bus word
    function automatic word_t zext_pins(input pins_t p);
        word_t w;
        w = '0;
        w[PIN_LO +: PIN_W] = p;
        return w;
    endfunction
endpackage

// File: rtl/ledsw_sync.sv
`timescale 1ns/1ps
module ledsw_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [0:W-1] d,
    output logic [0:W-1] q
);
    logic [0:W-1] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ledsw_ack.sv
`timescale 1ns/1ps
module ledsw_ack #(
    parameter int unsigned CE_W = 1
) (
    input  logic [0:CE_W-1] rd_ce,
    input  logic [0:CE_W-1] wr_ce,
    output logic            rd_ack,
    output logic            wr_ack,
    output logic            reg0_wr
);
    always_comb begin
        rd_ack  = |rd_ce;
        wr_ack  = |wr_ce;
        reg0_wr = wr_ce[0];
    end
endmodule

// File: rtl/ledsw_lane_reg.sv
`timescale 1ns/1ps
module ledsw_lane_reg
    import ledsw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    output word_t   q
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                q[k*LANE_W +: LANE_W] <= '0;
            end else if (req.hit && req.lane_en[k]) begin
                q[k*LANE_W +: LANE_W] <= req.data[k*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/ledsw_regblk.sv
`timescale 1ns/1ps
module ledsw_regblk
    import ledsw_pkg::*;
#(
    parameter int unsigned CE_W        = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [0:BUS_W-1]   wr_data,
    input  logic [0:LANES-1]   byte_en,
    input  logic [0:CE_W-1]    rd_ce,
    input  logic [0:CE_W-1]    wr_ce,
    output logic [0:BUS_W-1]   rd_data,
    output logic               rd_ack,
    output logic               wr_ack,
    output logic               err,
    input  logic [0:PIN_W-1]   sw_in,
    output logic [0:PIN_W-1]   led_out
);
    logic    reg0_wr;
    wr_req_t req;
    word_t   ctl_q;
    pins_t   sw_s;

    ledsw_ack #(.CE_W(CE_W)) u_ack (
        .rd_ce   (rd_ce),
        .wr_ce   (wr_ce),
        .rd_ack  (rd_ack),
        .wr_ack  (wr_ack),
        .reg0_wr (reg0_wr)
    );

    always_comb begin
        req.hit     = reg0_wr;
        req.lane_en = byte_en;
        req.data    = wr_data;
    end

    ledsw_lane_reg u_reg (
        .clk (clk),
        .rst (rst),
        .req (req),
        .q   (ctl_q)
    );

    ledsw_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sw_in),
        .q   (sw_s)
    );

    assign led_out = ctl_q[PIN_LO +: PIN_W];
    assign rd_data = zext_pins(sw_s);
    assign err     = 1'b0;
endmodule

// File: rtl/ledsw_regblk_chk.sv
`timescale 1ns/1ps
module ledsw_regblk_chk #(
    parameter int unsigned CE_W = 1
) (
    input logic          clk,
    input logic          rst,
    input logic [0:CE_W-1] rd_ce,
    input logic [0:CE_W-1] wr_ce,
    input logic          be_lsb,
    input logic [0:7]    wd_lsb,
    input logic [0:7]    sw_in,
    input logic [0:31]   rd_data,
    input logic [0:7]    led_out,
    input logic          rd_ack,
    input logic          wr_ack,
    input logic          err
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    p_led_clear_r1: assert property (@(posedge clk) rst |=> led_out == 8'h00)
        else $error("led not cleared by reset");
    p_lane_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ce[0] && be_lsb) |=> led_out == $past(wd_lsb))
        else $error("enabled lane not loaded");
    p_lane_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_ce[0] && be_lsb) |=> $stable(led_out))
        else $error("disabled lane changed");
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rd_data[0:23] == 24'h0)
        else $error("upper read bits not zero");
    p_sw_lag_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> rd_data[24:31] == $past(sw_in, 2))
        else $error("switch lag wrong");
    p_wr_ack_r6: assert property (@(posedge clk) disable iff (rst)
        wr_ack == ($countones(wr_ce) != 0))
        else $error("write ack mismatch");
    p_rd_ack_r6: assert property (@(posedge clk) disable iff (rst)
        rd_ack == ($countones(rd_ce) != 0))
        else $error("read ack mismatch");
    p_err_low_r7: assert property (@(posedge clk) disable iff (rst) !err)
        else $error("error flag raised");
endmodule

bind ledsw_regblk ledsw_regblk_chk #(.CE_W(CE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_ce   (rd_ce),
    .wr_ce   (wr_ce),
    .be_lsb  (byte_en[3]),
    .wd_lsb  (wr_data[24:31]),
    .sw_in   (sw_in),
    .rd_data (rd_data),
    .led_out (led_out),
    .rd_ack  (rd_ack),
    .wr_ack  (wr_ack),
    .err     (err)
);

// File: tb/tb_ledsw_regblk.sv
`timescale 1ns/1ps
module tb_ledsw_regblk;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [0:31] wr_data = '0;
    logic [0:3]  byte_en = '0;
    logic [0:0]  rd_ce = '0;
    logic [0:0]  wr_ce = '0;
    logic [0:31] rd_data;
    logic        rd_ack, wr_ack, err;
    logic [0:7]  sw_in = '0;
    logic [0:7]  led_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ledsw_regblk dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .byte_en(byte_en),
        .rd_ce(rd_ce), .wr_ce(wr_ce), .rd_data(rd_data), .rd_ack(rd_ack),
        .wr_ack(wr_ack), .err(err), .sw_in(sw_in), .led_out(led_out)
    );

    // {byte_en[0:3], wr_data, expected led after the write}
    localparam logic [43:0] VEC [8] = '{
        {4'hF, 32'h12345678, 8'h78},
        {4'h1, 32'hAABBCCDD, 8'hDD},
        {4'hE, 32'h000000FF, 8'hDD},
        {4'h0, 32'hFFFFFFFF, 8'hDD},
        {4'h1, 32'h00000000, 8'h00},
        {4'hF, 32'h800000A5, 8'hA5},
        {4'h1, 32'h0000003C, 8'h3C},
        {4'h2, 32'hFFFFFF00, 8'h3C}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 led after reset", {24'h0, led_out}, 32'h0);
        check("R1 rd_data after reset", rd_data, 32'h0);
        check("R7 err", {31'h0, err}, 32'h0);

        // table walk: byte-lane writes, LED byte observed
        for (int i = 0; i < 8; i++) begin
            byte_en = VEC[i][43:40];
            wr_data = VEC[i][39:8];
            wr_ce   = 1'b1;
            #1;
            check("R6 wr_ack same cycle", {31'h0, wr_ack}, 32'h1);
            check("R6 rd_ack idle", {31'h0, rd_ack}, 32'h0);
            @(posedge clk);
            @(negedge clk);
            wr_ce = 1'b0;
            check($sformatf("R2 R3 R9 vector %0d led", i), {24'h0, led_out}, {24'h0, VEC[i][7:0]});
        end

        // R10: write data and enables without chip enable
        byte_en = 4'hF; wr_data = 32'h000000FF; wr_ce = 1'b0;
        #1;
        check("R6 wr_ack low without ce", {31'h0, wr_ack}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R10 led unchanged", {24'h0, led_out}, 32'h3C);

        // R4/R5/R8: switch path, no read strobe
        sw_in = 8'hC3;
        @(posedge clk); @(negedge clk);
        check("R8 old value after one edge", rd_data, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R8 R5 new value after two edges", rd_data, 32'h000000C3);
        check("R4 read ignores register", rd_data, 32'h000000C3);

        // read with strobe
        sw_in = 8'hFF;
        rd_ce = 1'b1;
        #1;
        check("R6 rd_ack same cycle", {31'h0, rd_ack}, 32'h1);
        check("R6 wr_ack during read", {31'h0, wr_ack}, 32'h0);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R4 upper bits zero", rd_data, 32'h000000FF);
        rd_ce = 1'b0;
        #1;
        check("R6 rd_ack drops", {31'h0, rd_ack}, 32'h0);
        check("R7 err still low", {31'h0, err}, 32'h0);

        // R1: reset in mid-run
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 led cleared", {24'h0, led_out}, 32'h0);
        check("R1 sync cleared", rd_data, 32'h0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R8 value after reset release", rd_data, 32'h000000FF);

        done = 1'b1;
        finish_run();
    end
endmodule